// File: doc/BRIEF.md
# Raster Timing and Task Wakeup Sequencer

This block produces the raster timing of a bitmap display from two small lookup tables rather than from counter compares. A 32-entry horizontal table holds the state machine of one scan line. Each entry carries its own next state and the horizontal sync, horizontal blank, scan-end and line-gate signals. A 256-entry vertical table is addressed by the low byte of an 11-bit line counter and supplies vertical blank and sync for even and odd fields. The sequencer takes one step every `STEP_DIV` pixel clocks, 24 by default.

On each step the block compares every decoded table signal with its copy from the previous step. The edges it finds become single-cycle strobes. Set and clear strobes, one bit per task, go to four microcode tasks: the word task, the horizontal task, the vertical task and the cursor task. Further strobes clear the display FIFO and start word unloading. The block also keeps the block flags of the word, horizontal and cursor tasks, and it holds the video mode bits, which take effect only at the start of horizontal sync. Both tables reset to safe contents and can be rewritten through write ports at any time.

Top module: `raster_seq`

## Requirements
- R1: A step occurs on every `STEP_DIV`-th clock, the first one on the `STEP_DIV`-th rising edge after reset. `state_o` then takes the value {~line_o[0], entry[5:2]}, where entry is the horizontal table word at the old `state_o`. All strobes are registered and appear only in the cycle that follows a step.
- R2: Horizontal entry layout: bit 0 sync, bit 1 blank, bits 5..2 next state, bit 6 scan end, bit 7 line gate. When the current entry has its gate bit set, `line_o` increments by one at the step and wraps modulo 2048.
- R3: The vertical table is read at line_o[7:0]. Its output is forced to 4'hF when line_o[8] or line_o[9] is set. Its bits are active low: bit 0 blank for even fields, bit 1 blank for odd fields, bit 2 sync for even fields, bit 3 sync for odd fields. line_o[10] selects the odd bits. `vblank_o` and `vsync_o` show the decoded active-high values from the last step.
- R4: At each step inside vertical blank, `vblank_line_o` takes `line_o` with bit 10 cleared. Outside vertical blank it holds its value.
- R5: A rising edge of vertical sync inside vertical blank pulses wake_set_o[2] (vertical task).
- R6: A falling edge of vertical blank pulses wake_set_o[1] (horizontal task) and clears the word, horizontal and cursor block flags.
- R7: A falling edge of horizontal blank outside vertical blank pulses `unload_start_o`. It sets `unload_len_o` to 32 when half-clock mode is in effect and to 16 otherwise.
- R8: At every step where the word and horizontal block flags are both clear and `fifo_stopwake_i` is high, wake_set_o[0] pulses. A set scan-end bit instead pulses wake_clr_o[0] and suppresses that set.
- R9: A rising edge of horizontal sync pulses `fifo_clr_o` and clears the word block flag. At the same time it moves the pending mode (mode_data_i bit 0 inverse, bit 1 half-clock, captured by `mode_set_i`) into `inverse_o` and `halfclock_o`.
- R10: A falling edge of horizontal sync pulses wake_set_o[3] (cursor task) unless the cursor block flag is set.
- R11: `word_block_i`, `horz_block_i` and `curs_block_i` set their block flags. A clear caused by a step in the same cycle takes precedence.
- R12: After reset the outputs are zero except `unload_len_o`, which is 16. Horizontal entry i holds next state (i+1) mod 16 with all signal bits clear, and every vertical entry is 4'hF.
- R13: A table write takes effect from the next clock. A step in the same cycle as the write still reads the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hprom_we_i | input | 1 | Horizontal table write enable |
| hprom_addr_i | input | 5 | Horizontal table write address |
| hprom_data_i | input | 8 | Horizontal table write data |
| vprom_we_i | input | 1 | Vertical table write enable |
| vprom_addr_i | input | 8 | Vertical table write address |
| vprom_data_i | input | 4 | Vertical table write data |
| fifo_stopwake_i | input | 1 | FIFO able to accept words |
| word_block_i | input | 1 | Word task executed block |
| horz_block_i | input | 1 | Horizontal task executed block |
| curs_block_i | input | 1 | Cursor task executed block |
| mode_set_i | input | 1 | Capture pending mode |
| mode_data_i | input | 2 | Pending mode: bit 0 inverse, bit 1 half-clock |
| wake_set_o | output | 4 | Per-task wakeup set strobes |
| wake_clr_o | output | 4 | Per-task wakeup clear strobes |
| fifo_clr_o | output | 1 | FIFO pointer clear strobe |
| unload_start_o | output | 1 | Word unload start strobe |
| unload_len_o | output | 6 | First word time in pixel clocks |
| inverse_o | output | 1 | Inverse video in effect |
| halfclock_o | output | 1 | Half-clock mode in effect |
| line_o | output | 11 | Line counter |
| vblank_line_o | output | 11 | Most recent blanking line |
| state_o | output | 5 | Horizontal table address |
| hblank_o | output | 1 | Horizontal blank at last step |
| hsync_o | output | 1 | Horizontal sync at last step |
| vblank_o | output | 1 | Vertical blank at last step |
| vsync_o | output | 1 | Vertical sync at last step |

## Verification
The first run uses the reset contents of both tables. With every signal bit clear, no edges occur, and the run shows that the next-state chain alone drives `state_o`. The bench then writes a line program while the sequencer runs, so steps that read old table words are told apart from steps that read new ones. The upper and lower halves of the horizontal table differ in one scan-end bit, which separates even and odd lines and confirms that line bit 0 feeds the address. The vertical table uses different blank and sync windows per field, so two full frames show the field select, the table disable for lines 256 to 1023, and the sync-inside-blank rule. Random block, stop-wake and mode-set inputs cover the set-against-clear races on the flags and the deferred latching of the mode.

// File: rtl/raster_seq_pkg.sv
package raster_seq_pkg;
  localparam int HADDR_W = 5;
  localparam int HDATA_W = 8;
  localparam int VADDR_W = 8;
  localparam int VDATA_W = 4;
  localparam int LINE_W  = 11;
  localparam int TASK_N  = 4;

  typedef enum logic [1:0] {
    TASK_WORD = 2'd0,
    TASK_HORZ = 2'd1,
    TASK_VERT = 2'd2,
    TASK_CURS = 2'd3
  } task_e;

  // horizontal table word; next-state field position is fixed by the address path
  typedef struct packed {
    logic       gate;
    logic       scanend;
    logic [3:0] nxt;
    logic       hblank;
    logic       hsync;
  } hword_t;

  // vertical table bits, active low
  localparam int VB_BLANK_EVEN = 0;
  localparam int VB_BLANK_ODD  = 1;
  localparam int VB_SYNC_EVEN  = 2;
  localparam int VB_SYNC_ODD   = 3;

  localparam int UNLOAD_FULL = 16;
  localparam int UNLOAD_HALF = 32;
endpackage

// File: rtl/raster_step_div.sv
module raster_step_div #(
  parameter int STEP_DIV = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic step_o
);
  localparam int CNT_W = $clog2(STEP_DIV + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign step_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_step_restart_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> (cnt_q == '0));
endmodule

// File: rtl/raster_prom.sv
module raster_prom #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter bit HORZ   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    // horizontal default: chain to the next state, all signals idle
    localparam logic [DATA_W-1:0] RST_VAL =
      HORZ ? DATA_W'(((i + 1) % 16) << 2) : {DATA_W{1'b1}};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[i] <= RST_VAL;
      else if (we_i && (wr_addr_i == ADDR_W'(i)))
        mem_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  assert_write_lands_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(wr_addr_i)] == $past(wr_data_i)));
endmodule

// File: rtl/raster_task_flags.sv
module raster_task_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       word_set_i,
  input  logic       horz_set_i,
  input  logic       curs_set_i,
  input  logic       clr_vfall_i,
  input  logic       clr_hrise_i,
  input  logic       mode_set_i,
  input  logic [1:0] mode_data_i,
  output logic       word_blk_o,
  output logic       horz_blk_o,
  output logic       curs_blk_o,
  output logic       inverse_o,
  output logic       halfclock_o
);
  logic [1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_blk_o  <= 1'b0;
      horz_blk_o  <= 1'b0;
      curs_blk_o  <= 1'b0;
      pend_q      <= '0;
      inverse_o   <= 1'b0;
      halfclock_o <= 1'b0;
    end else begin
      if (clr_vfall_i || clr_hrise_i) word_blk_o <= 1'b0;
      else if (word_set_i)            word_blk_o <= 1'b1;
      if (clr_vfall_i)                horz_blk_o <= 1'b0;
      else if (horz_set_i)            horz_blk_o <= 1'b1;
      if (clr_vfall_i)                curs_blk_o <= 1'b0;
      else if (curs_set_i)            curs_blk_o <= 1'b1;
      if (clr_hrise_i) begin
        inverse_o   <= pend_q[0];
        halfclock_o <= pend_q[1];
      end
      if (mode_set_i) pend_q <= mode_data_i;
    end
  end

  assert_vfall_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_vfall_i |=> (!word_blk_o && !horz_blk_o && !curs_blk_o));
  assert_hrise_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_hrise_i |=> !word_blk_o);
  assert_mode_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_hrise_i |=> ($stable(inverse_o) && $stable(halfclock_o)));
endmodule

// File: rtl/raster_seq.sv
module raster_seq
  import raster_seq_pkg::*;
#(
  parameter int STEP_DIV = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hprom_we_i,
  input  logic [HADDR_W-1:0] hprom_addr_i,
  input  logic [HDATA_W-1:0] hprom_data_i,
  input  logic               vprom_we_i,
  input  logic [VADDR_W-1:0] vprom_addr_i,
  input  logic [VDATA_W-1:0] vprom_data_i,
  input  logic               fifo_stopwake_i,
  input  logic               word_block_i,
  input  logic               horz_block_i,
  input  logic               curs_block_i,
  input  logic               mode_set_i,
  input  logic [1:0]         mode_data_i,
  output logic [TASK_N-1:0]  wake_set_o,
  output logic [TASK_N-1:0]  wake_clr_o,
  output logic               fifo_clr_o,
  output logic               unload_start_o,
  output logic [5:0]         unload_len_o,
  output logic               inverse_o,
  output logic               halfclock_o,
  output logic [LINE_W-1:0]  line_o,
  output logic [LINE_W-1:0]  vblank_line_o,
  output logic [HADDR_W-1:0] state_o,
  output logic               hblank_o,
  output logic               hsync_o,
  output logic               vblank_o,
  output logic               vsync_o
);
  localparam logic [LINE_W-1:0] FIELD_MASK = ~(LINE_W'(1) << (LINE_W - 1));

  logic               step;
  logic [HDATA_W-1:0] h_raw;
  logic [VDATA_W-1:0] v_raw, v_eff;
  hword_t             hw;
  logic               odd, v_off, vb_now, vs_now;
  logic               word_blk, horz_blk, curs_blk;
  logic               ev_vs_rise, ev_vb_fall, ev_hb_fall, ev_hs_rise, ev_hs_fall;
  logic               word_wake, word_drop, curs_wake;
  logic [TASK_N-1:0]  set_d, clr_d;

  raster_step_div #(.STEP_DIV(STEP_DIV)) u_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .step_o(step)
  );

  raster_prom #(.ADDR_W(HADDR_W), .DATA_W(HDATA_W), .HORZ(1'b1)) u_hprom (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(hprom_we_i), .wr_addr_i(hprom_addr_i),
    .wr_data_i(hprom_data_i), .rd_addr_i(state_o), .rd_data_o(h_raw)
  );

  raster_prom #(.ADDR_W(VADDR_W), .DATA_W(VDATA_W), .HORZ(1'b0)) u_vprom (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(vprom_we_i), .wr_addr_i(vprom_addr_i),
    .wr_data_i(vprom_data_i), .rd_addr_i(line_o[VADDR_W-1:0]), .rd_data_o(v_raw)
  );

  always_comb begin
    hw     = hword_t'(h_raw);
    odd    = line_o[LINE_W-1];
    v_off  = line_o[8] | line_o[9];
    v_eff  = v_off ? {VDATA_W{1'b1}} : v_raw;
    vb_now = ~(odd ? v_eff[VB_BLANK_ODD] : v_eff[VB_BLANK_EVEN]);
    vs_now = ~(odd ? v_eff[VB_SYNC_ODD]  : v_eff[VB_SYNC_EVEN]);

    ev_vs_rise = step & vb_now & vs_now & ~vsync_o;
    ev_vb_fall = step & ~vb_now & vblank_o;
    ev_hb_fall = step & ~vb_now & ~hw.hblank & hblank_o;
    ev_hs_rise = step & hw.hsync & ~hsync_o;
    ev_hs_fall = step & ~hw.hsync & hsync_o;
    word_drop  = step & hw.scanend;
    word_wake  = step & ~word_blk & ~horz_blk & fifo_stopwake_i & ~hw.scanend;
    curs_wake  = ev_hs_fall & ~curs_blk;

    set_d            = '0;
    set_d[TASK_WORD] = word_wake;
    set_d[TASK_HORZ] = ev_vb_fall;
    set_d[TASK_VERT] = ev_vs_rise;
    set_d[TASK_CURS] = curs_wake;
    clr_d            = '0;
    clr_d[TASK_WORD] = word_drop;
  end

  raster_task_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_set_i  (word_block_i),
    .horz_set_i  (horz_block_i),
    .curs_set_i  (curs_block_i),
    .clr_vfall_i (ev_vb_fall),
    .clr_hrise_i (ev_hs_rise),
    .mode_set_i  (mode_set_i),
    .mode_data_i (mode_data_i),
    .word_blk_o  (word_blk),
    .horz_blk_o  (horz_blk),
    .curs_blk_o  (curs_blk),
    .inverse_o   (inverse_o),
    .halfclock_o (halfclock_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_set_o     <= '0;
      wake_clr_o     <= '0;
      fifo_clr_o     <= 1'b0;
      unload_start_o <= 1'b0;
      unload_len_o   <= 6'(UNLOAD_FULL);
      line_o         <= '0;
      vblank_line_o  <= '0;
      state_o        <= '0;
      hblank_o       <= 1'b0;
      hsync_o        <= 1'b0;
      vblank_o       <= 1'b0;
      vsync_o        <= 1'b0;
    end else begin
      wake_set_o     <= set_d;
      wake_clr_o     <= clr_d;
      fifo_clr_o     <= ev_hs_rise;
      unload_start_o <= ev_hb_fall;
      if (ev_hb_fall)
        unload_len_o <= halfclock_o ? 6'(UNLOAD_HALF) : 6'(UNLOAD_FULL);
      if (step) begin
        state_o  <= {~line_o[0], hw.nxt};
        line_o   <= line_o + LINE_W'(hw.gate);
        if (vb_now) vblank_line_o <= line_o & FIELD_MASK;
        hblank_o <= hw.hblank;
        hsync_o  <= hw.hsync;
        vblank_o <= vb_now;
        vsync_o  <= vs_now;
      end
    end
  end

  assert_strobe_after_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wake_set_o || |wake_clr_o || fifo_clr_o || unload_start_o) |-> $past(step));
  assert_vert_wake_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_set_o[TASK_VERT] |-> (vsync_o && vblank_o && !$past(vsync_o)));
  assert_horz_wake_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_set_o[TASK_HORZ] |-> (!vblank_o && $past(vblank_o)));
  assert_unload_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unload_start_o |-> (unload_len_o == 6'(UNLOAD_FULL) || unload_len_o == 6'(UNLOAD_HALF)));
  assert_scanend_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_clr_o[TASK_WORD] |-> !wake_set_o[TASK_WORD]);
  assert_fifo_clr_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_o |-> (hsync_o && !$past(hsync_o)));
  assert_curs_wake_edge_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_set_o[TASK_CURS] |-> (!hsync_o && $past(hsync_o)));
  assert_vline_field_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vblank_line_o[LINE_W-1]);
  assert_line_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(step) |-> $stable(line_o));
endmodule

// File: tb/raster_seq_test.sv
module raster_seq_test;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       hwe = 0, vwe = 0;
  logic [4:0] hadr = 0;
  logic [7:0] hdat = 0, vadr = 0;
  logic [3:0] vdat = 0;
  logic       stopwake = 0, wblk = 0, hblk = 0, cblk = 0, mset = 0;
  logic [1:0] mdat = 0;

  logic [3:0]  wset, wclr;
  logic        fclr, ustart, inv, half, hb, hs, vb, vs;
  logic [5:0]  ulen;
  logic [10:0] line, vline;
  logic [4:0]  st;

  raster_seq #(.STEP_DIV(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .hprom_we_i(hwe), .hprom_addr_i(hadr), .hprom_data_i(hdat),
    .vprom_we_i(vwe), .vprom_addr_i(vadr), .vprom_data_i(vdat),
    .fifo_stopwake_i(stopwake), .word_block_i(wblk), .horz_block_i(hblk),
    .curs_block_i(cblk), .mode_set_i(mset), .mode_data_i(mdat),
    .wake_set_o(wset), .wake_clr_o(wclr), .fifo_clr_o(fclr),
    .unload_start_o(ustart), .unload_len_o(ulen), .inverse_o(inv),
    .halfclock_o(half), .line_o(line), .vblank_line_o(vline), .state_o(st),
    .hblank_o(hb), .hsync_o(hs), .vblank_o(vb), .vsync_o(vs)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int   m_cnt, m_state, m_line, m_vline, m_len;
  bit   m_hbq, m_hsq, m_vbq, m_vsq, m_wb, m_hbk, m_cb, m_inv, m_half;
  int   m_pend;
  bit [3:0] m_wset, m_wclr;
  bit   m_fclr, m_us;
  bit [7:0] m_h [32];
  bit [3:0] m_v [256];
  int   cnt_vert = 0, cnt_horz = 0, cnt_curs = 0, cnt_word = 0, cnt_drop = 0;
  int   cnt_us16 = 0, cnt_us32 = 0, cnt_fclr = 0, max_line = 0;

  function automatic bit [7:0] hprog(int a);
    int  s = a % 8;
    bit  up = a[4];
    bit [7:0] w = '0;
    w[0]   = (s < 2);
    w[1]   = (s <= 2) || (s == 7);
    w[5:2] = 4'((s + 1) % 8);
    w[6]   = (s == 6) || (up && s == 5);
    w[7]   = (s == 7);
    return w;
  endfunction

  function automatic bit [3:0] vprog(int a);
    return {!(a >= 4 && a <= 6), !(a >= 3 && a <= 5), !(a < 13), !(a < 10)};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_state = 0; m_line = 0; m_vline = 0; m_len = 16;
      m_hbq = 0; m_hsq = 0; m_vbq = 0; m_vsq = 0;
      m_wb = 0; m_hbk = 0; m_cb = 0; m_inv = 0; m_half = 0; m_pend = 0;
      m_wset = 0; m_wclr = 0; m_fclr = 0; m_us = 0;
      for (int i = 0; i < 32; i++) m_h[i] = 8'(((i + 1) % 16) << 2);
      for (int i = 0; i < 256; i++) m_v[i] = 4'hF;
    end else begin
      bit step, cv, cr;
      bit [7:0] h;
      bit [3:0] v;
      bit odd, vbn, vsn;
      step = (m_cnt == DIV - 1);
      m_cnt = step ? 0 : m_cnt + 1;
      m_wset = 0; m_wclr = 0; m_fclr = 0; m_us = 0; cv = 0; cr = 0;
      if (step) begin
        h = m_h[m_state];
        v = (m_line >= 256 && (m_line % 1024) < 1024 && ((m_line / 256) % 4) != 0) ? 4'hF : m_v[m_line % 256];
        odd = (m_line >= 1024);
        vbn = !(odd ? v[1] : v[0]);
        vsn = !(odd ? v[3] : v[2]);
        cv = !vbn && m_vbq;
        cr = h[0] && !m_hsq;
        if (vbn && vsn && !m_vsq) m_wset[2] = 1;
        if (cv) m_wset[1] = 1;
        if (!vbn && !h[1] && m_hbq) begin m_us = 1; m_len = m_half ? 32 : 16; end
        if (h[6]) m_wclr[0] = 1;
        else if (!m_wb && !m_hbk && stopwake) m_wset[0] = 1;
        if (!h[0] && m_hsq && !m_cb) m_wset[3] = 1;
        m_fclr = cr;
        if (cv) begin m_wb = 0; m_hbk = 0; m_cb = 0; end
        if (cr) begin m_wb = 0; m_inv = m_pend[0]; m_half = m_pend[1]; end
        if (vbn) m_vline = m_line % 1024;
        m_state = ((m_line % 2) ? 0 : 16) + h[5:2];
        m_line = (m_line + h[7]) % 2048;
        m_hbq = h[1]; m_hsq = h[0]; m_vbq = vbn; m_vsq = vsn;
      end
      if (!(step && (cv || cr)) && wblk) m_wb = 1;
      if (!(step && cv) && hblk) m_hbk = 1;
      if (!(step && cv) && cblk) m_cb = 1;
      if (mset) m_pend = mdat;
      if (hwe) m_h[hadr] = hdat;
      if (vwe) m_v[vadr] = vdat;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 state", st, m_state);
      chk("R2 line", line, m_line);
      chk("R3 raster flags", {hb, hs, vb, vs}, {m_hbq, m_hsq, m_vbq, m_vsq});
      chk("R4 vblank line", vline, m_vline);
      chk("R5 R6 R8 R10 wake set", wset, m_wset);
      chk("R8 wake clear", wclr, m_wclr);
      chk("R7 unload", {ustart, ulen}, {m_us, 6'(m_len)});
      chk("R9 fifo clear and mode", {fclr, inv, half}, {m_fclr, m_inv, m_half});
      if (wset[2]) cnt_vert++;
      if (wset[1]) cnt_horz++;
      if (wset[3]) cnt_curs++;
      if (wset[0]) cnt_word++;
      if (wclr[0]) cnt_drop++;
      if (fclr) cnt_fclr++;
      if (ustart && ulen == 16) cnt_us16++;
      if (ustart && ulen == 32) cnt_us32++;
      if (line > max_line) max_line = line;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset values
    chk("R12 reset outputs", {wset, wclr, fclr, ustart, inv, half, hb, hs, vb, vs},
        '0);
    chk("R12 reset counters", {line, vline, st}, '0);
    chk("R12 reset unload length", ulen, 6'd16);
    rst_n = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      stopwake = $urandom_range(0, 1);
    end
    // R12 default chain: signals idle, line counter untouched
    chk("R12 default table line", line, 11'd0);
    // R13 rewrite tables while stepping
    for (int a = 0; a < 32; a++) begin
      hwe = 1; hadr = 5'(a); hdat = hprog(a);
      @(negedge clk);
    end
    hwe = 0;
    for (int a = 0; a < 256; a++) begin
      vwe = 1; vadr = 8'(a); vdat = vprog(a);
      @(negedge clk);
    end
    vwe = 0;
    for (int i = 0; i < 70000; i++) begin
      stopwake = ($urandom_range(0, 3) != 0);
      wblk = ($urandom_range(0, 40) == 0);
      hblk = ($urandom_range(0, 60) == 0);
      cblk = ($urandom_range(0, 30) == 0);
      mset = ($urandom_range(0, 200) == 0);
      mdat = 2'($urandom_range(0, 3));
      @(negedge clk);
    end
    done = 1;
    chk("R2 line wrap reached", (max_line >= 2000) ? 1 : 0, 1);
    chk("R5 vertical wakes seen", (cnt_vert >= 3) ? 1 : 0, 1);
    chk("R6 horizontal wakes seen", (cnt_horz >= 3) ? 1 : 0, 1);
    chk("R7 both unload lengths", ((cnt_us16 > 0) && (cnt_us32 > 0)) ? 1 : 0, 1);
    chk("R8 word wake and drop seen", ((cnt_word > 0) && (cnt_drop > 0)) ? 1 : 0, 1);
    chk("R9 fifo clears seen", (cnt_fclr > 0) ? 1 : 0, 1);
    chk("R10 cursor wakes seen", (cnt_curs > 0) ? 1 : 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule